// File: doc/BRIEF.md
# PCI Target Read Latency Retry Controller

This block watches a PCI target's read path and counts bus clocks while the target waits for read data from an internal source. It gives the first data phase of a read a budget of 32 clocks and every later data phase a budget of 8 clocks. When a budget runs out and latency enforcement is on, it asks the bus interface to stop the transaction. A stop raised before any data has moved is a retry. A stop raised after at least one data phase is a disconnect. The `any_xfer` output tells the two apart.

A second rule can refuse a read at once. If posted-write retry is enabled and posted writes are still pending when a read starts, the read is retried on the next clock. This rule holds whatever the setting of latency enforcement. Once the stop request is raised, it stays up until the bus interface reports the end of the transaction.

The controller is a five-state machine:
- `ST_IDLE`: no transaction.
- `ST_WAIT_FIRST`: waiting for the first data.
- `ST_WAIT_NEXT`: waiting for later data.
- `ST_DATA`: data is ready and waits to be taken on the bus.
- `ST_STOP`: a stop is being requested.

The transitions are:
- IDLE→STOP on a start while posted writes block reads.
- IDLE→WAIT_FIRST on any other start.
- WAIT_x→DATA on data-ready.
- WAIT_x→STOP when the budget expires with enforcement on.
- DATA→WAIT_NEXT on a transfer.
- Any busy state→IDLE on transaction end.

Top module: `pci_lat_ctrl`

## Requirements
- R1: After reset, `stop_req` and `any_xfer` are 0 and the block is idle.
- R2: With `lat_en`=1, if `data_rdy` stays low on the 32 clock edges that follow the start edge, `stop_req` is 1 after the 32nd edge and `any_xfer` is 0, which marks a retry.
- R3: With `lat_en`=1, if `data_rdy` stays low on the 8 edges that follow a transfer edge, `stop_req` is 1 after the 8th edge and `any_xfer` is 1, which marks a disconnect. After 7 such edges `stop_req` is still 0.
- R4: With `lat_en`=0, `stop_req` never rises during a wait, however long the wait lasts.
- R5: A start seen with `pw_retry_en`=1 and `pw_pending`=1 gives `stop_req`=1 and `any_xfer`=0 one edge later, for either value of `lat_en`. If only one of those two inputs is 1, the start is not refused.
- R6: The wait count restarts at the start edge and at every transfer edge. Each later phase gets a full 8-clock budget, even after a first phase that used 31 clocks.
- R7: If `data_rdy` is 1 on the very edge at which the budget would run out, the data phase proceeds and no stop is raised.
- R8: Once raised, `stop_req` stays at 1 until an edge with `txn_end`=1. After that edge the block is idle and `stop_req` is 0.
- R9: `any_xfer` is cleared by a start edge, set by a `data_xfer` edge while data is ready, and held through the end of the transaction until the next start.
- R10: The wait counter saturates and does not wrap. After 130 clocks of waiting with `lat_en`=0, setting `lat_en` to 1 raises `stop_req` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | A read transaction begins (seen when idle) |
| data_rdy | input | 1 | Internal source has data for the current phase |
| data_xfer | input | 1 | The ready data phase completed on the bus |
| txn_end | input | 1 | The transaction has ended on the bus |
| lat_en | input | 1 | Enable latency-budget enforcement |
| pw_pending | input | 1 | Posted writes are still pending |
| pw_retry_en | input | 1 | Enable retry of reads while posted writes are pending |
| stop_req | output | 1 | Request to terminate the transaction |
| any_xfer | output | 1 | At least one data phase has transferred in this transaction |

## Verification
Each result has a fixed due cycle:
- A posted-write refusal is due one edge after the start edge.
- A first-phase expiry is due exactly 32 edges after the start edge.
- A later-phase expiry is due 8 edges after the transfer edge.
- The end of a stop is due one edge after `txn_end`.

The bench drives every input on the falling clock edge and counts rising edges exactly. It samples at the falling edge right after the edge on which a result is due. For each budget it also samples one edge earlier, or moves `data_rdy` onto the limit edge, so that a stop raised one clock too early or too late is caught.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FIRST,
        ST_WAIT_NEXT,
        ST_DATA,
        ST_STOP
    } lat_state_t;

endpackage

// File: rtl/pci_lat_counter.sv
module pci_lat_counter #(
    parameter int INIT_LIM = 32,
    parameter int BEAT_LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cnt_en,
    input  logic sel_first,
    output logic at_limit
);
    localparam int CW = $clog2(INIT_LIM + 1);
    localparam logic [CW-1:0] CMAX     = '1;
    localparam logic [CW-1:0] INIT_THR = CW'(INIT_LIM - 1);
    localparam logic [CW-1:0] BEAT_THR = CW'(BEAT_LIM - 1);

    logic [CW-1:0] wait_cnt;
    logic [CW-1:0] thr;

    // count clocks spent waiting; hold at the top value instead of wrapping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (clr) begin
            wait_cnt <= '0;
        end else if (cnt_en && (wait_cnt != CMAX)) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    always_comb begin
        thr      = sel_first ? INIT_THR : BEAT_THR;
        at_limit = (wait_cnt >= thr);
    end

endmodule

// File: rtl/pci_lat_fsm.sv
module pci_lat_fsm
    import pci_lat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txn_start,
    input  logic data_rdy,
    input  logic data_xfer,
    input  logic txn_end,
    input  logic lat_en,
    input  logic pw_pending,
    input  logic pw_retry_en,
    input  logic at_limit,
    output logic cnt_clr,
    output logic cnt_en,
    output logic sel_first,
    output logic stop_req,
    output logic any_xfer,
    output logic busy
);
    lat_state_t state, nxt;
    logic       waiting;
    logic       pw_block;

    always_comb begin
        pw_block = pw_retry_en && pw_pending;
        waiting  = (state == ST_WAIT_FIRST) || (state == ST_WAIT_NEXT);
    end

    // state register and transfer flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            any_xfer <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == ST_IDLE) && txn_start) begin
                any_xfer <= 1'b0;
            end else if ((state == ST_DATA) && data_xfer) begin
                any_xfer <= 1'b1;
            end
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (txn_start) begin
                    nxt = pw_block ? ST_STOP : ST_WAIT_FIRST;
                end
            end
            ST_WAIT_FIRST, ST_WAIT_NEXT: begin
                if (txn_end) begin
                    nxt = ST_IDLE;
                end else if (data_rdy) begin
                    nxt = ST_DATA;
                end else if (lat_en && at_limit) begin
                    nxt = ST_STOP;
                end
            end
            ST_DATA: begin
                if (txn_end) begin
                    nxt = ST_IDLE;
                end else if (data_xfer) begin
                    nxt = ST_WAIT_NEXT;
                end
            end
            ST_STOP: begin
                if (txn_end) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_clr   = ((state == ST_IDLE) && txn_start) ||
                    ((state == ST_DATA) && data_xfer);
        cnt_en    = waiting && !data_rdy;
        sel_first = (state == ST_WAIT_FIRST);
        stop_req  = (state == ST_STOP);
        busy      = (state != ST_IDLE);
    end

endmodule

// File: rtl/pci_lat_ctrl.sv
module pci_lat_ctrl #(
    parameter int INIT_LIM = 32,
    parameter int BEAT_LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txn_start,
    input  logic data_rdy,
    input  logic data_xfer,
    input  logic txn_end,
    input  logic lat_en,
    input  logic pw_pending,
    input  logic pw_retry_en,
    output logic stop_req,
    output logic any_xfer
);
    logic cnt_clr;
    logic cnt_en;
    logic sel_first;
    logic at_limit;
    logic busy;

    pci_lat_counter #(
        .INIT_LIM (INIT_LIM),
        .BEAT_LIM (BEAT_LIM)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .cnt_en    (cnt_en),
        .sel_first (sel_first),
        .at_limit  (at_limit)
    );

    pci_lat_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .data_rdy    (data_rdy),
        .data_xfer   (data_xfer),
        .txn_end     (txn_end),
        .lat_en      (lat_en),
        .pw_pending  (pw_pending),
        .pw_retry_en (pw_retry_en),
        .at_limit    (at_limit),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .sel_first   (sel_first),
        .stop_req    (stop_req),
        .any_xfer    (any_xfer),
        .busy        (busy)
    );

endmodule

// File: rtl/pci_lat_ctrl_chk.sv
module pci_lat_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic txn_start,
    input logic txn_end,
    input logic lat_en,
    input logic pw_pending,
    input logic pw_retry_en,
    input logic stop_req,
    input logic any_xfer,
    input logic busy
);
    AST_PW_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && txn_start && pw_retry_en && pw_pending) |=> (stop_req && !any_xfer)); // R5

    AST_NO_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop_req && !lat_en) |=> !stop_req); // R4

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !txn_end) |=> stop_req); // R8

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txn_end) |=> (!busy && !stop_req)); // R8

    AST_STOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> busy); // R8

    AST_XFER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_xfer && !(!busy && txn_start)) |=> any_xfer); // R9

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && txn_start) |=> !any_xfer); // R9

endmodule

bind pci_lat_ctrl pci_lat_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .txn_end     (txn_end),
    .lat_en      (lat_en),
    .pw_pending  (pw_pending),
    .pw_retry_en (pw_retry_en),
    .stop_req    (stop_req),
    .any_xfer    (any_xfer),
    .busy        (busy)
);

// File: tb/pci_lat_ctrl_test.sv
module pci_lat_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0;
    logic data_rdy = 1'b0;
    logic data_xfer = 1'b0;
    logic txn_end = 1'b0;
    logic lat_en = 1'b0;
    logic pw_pending = 1'b0;
    logic pw_retry_en = 1'b0;
    logic stop_req;
    logic any_xfer;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pci_lat_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .data_rdy    (data_rdy),
        .data_xfer   (data_xfer),
        .txn_end     (txn_end),
        .lat_en      (lat_en),
        .pw_pending  (pw_pending),
        .pw_retry_en (pw_retry_en),
        .stop_req    (stop_req),
        .any_xfer    (any_xfer)
    );

    // fields: lat_en, pw_retry_en, pw_pending, wait clocks, expected stop, expected any_xfer
    localparam int NVEC = 10;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 8'd5,   1'b0, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'd31,  1'b0, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'd32,  1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'd40,  1'b1, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'd40,  1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 8'd200, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b1, 8'd0,   1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd3,   1'b0, 1'b1},
        {1'b1, 1'b0, 1'b1, 8'd3,   1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'd0,   1'b1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic start_txn();
        txn_start = 1'b1;
        tick(1);
        txn_start = 1'b0;
    endtask

    task automatic give_data();
        data_rdy = 1'b1;
        tick(1);
        data_rdy  = 1'b0;
        data_xfer = 1'b1;
        tick(1);
        data_xfer = 1'b0;
    endtask

    task automatic end_txn();
        txn_end = 1'b1;
        tick(1);
        txn_end = 1'b0;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1", stop_req, 1'b0, "stop_req in reset");
        check("R1", any_xfer, 1'b0, "any_xfer in reset");
        rst_n = 1'b1;
        tick(2);
        check("R1", stop_req, 1'b0, "stop_req after reset");
        check("R1", any_xfer, 1'b0, "any_xfer after reset");

        // table of read scenarios
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] e;
            string       req;
            int          w;
            e           = VEC[v];
            lat_en      = e[12];
            pw_retry_en = e[11];
            pw_pending  = e[10];
            w           = int'(e[9:2]);
            if (e[11] && e[10])  req = "R5";
            else if (!e[12])     req = "R4";
            else if (w == 31)    req = "R7";
            else                 req = "R2";
            start_txn();
            tick(w);
            check(req, stop_req, e[1], $sformatf("stop_req vec %0d", v));
            give_data();
            check("R9", any_xfer, e[0], $sformatf("any_xfer vec %0d", v));
            end_txn();
            check("R8", stop_req, 1'b0, $sformatf("stop_req after end vec %0d", v));
        end
        lat_en = 1'b1;
        pw_retry_en = 1'b0;
        pw_pending = 1'b0;

        // R3 later-phase budget, then R8 hold and R9 flag behaviour
        start_txn();
        give_data();
        tick(7);
        check("R3", stop_req, 1'b0, "stop_req after 7 beat clocks");
        tick(1);
        check("R3", stop_req, 1'b1, "stop_req after 8 beat clocks");
        check("R3", any_xfer, 1'b1, "disconnect flag");
        tick(5);
        check("R8", stop_req, 1'b1, "stop_req held");
        end_txn();
        check("R8", stop_req, 1'b0, "stop_req after end");
        check("R9", any_xfer, 1'b1, "any_xfer held after end");
        start_txn();
        check("R9", any_xfer, 1'b0, "any_xfer cleared by start");
        end_txn();

        // R6 restart of the count; R7 data on the limit edge of a later phase
        start_txn();
        tick(31);
        give_data();
        check("R6", stop_req, 1'b0, "no stop after 31-clock first phase");
        tick(7);
        give_data();
        check("R7", stop_req, 1'b0, "data on the 8th beat clock");
        check("R6", any_xfer, 1'b1, "transfers counted");
        tick(8);
        check("R6", stop_req, 1'b1, "full beat budget after restart");
        end_txn();

        // R10 saturation
        lat_en = 1'b0;
        start_txn();
        tick(130);
        check("R4", stop_req, 1'b0, "no stop while disabled");
        lat_en = 1'b1;
        tick(1);
        check("R10", stop_req, 1'b1, "saturated count stops at once");
        check("R10", any_xfer, 1'b0, "retry kind");
        end_txn();
        check("R8", stop_req, 1'b0, "idle after end");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule